// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the host-facing half of an I2C master peripheral. A processor reaches it through a simple word bus with byte offsets. Through that bus it sets the target address, the byte count, the prescaler and the two SCL phase lengths, starts and stops transfers, and moves payload bytes. A separate bit-level engine does the timing on the wire. The front end gives that engine a start pulse, the direction, the address, the count and a stream of transmit bytes. It takes back received bytes and the bus events: arbitration lost, no acknowledge, transfer finished, and bus busy.

Payload bytes travel two to a 16-bit data access. The byte that goes first on the wire sits in bits 7:0. Status flags are sticky and are cleared by writing ones. The interrupt line is the OR of the enabled flags, and a vector register names the lowest-numbered pending source. A control-register enable bit holds the datapath idle when it is clear. A soft-reset request returns every register to its default and keeps a reset-done flag low while the reset runs.

Top module: `i2c_host_regs`

## Requirements
- R1: After power-on reset, control (0x24), status (0x08), interrupt enable (0x04) and prescaler (0x30) read 0, irq is low, system status (0x10) bit0 reads 1 and offset 0x00 reads the REV_ID parameter.
- R2: Status flags (bit0 arbitration lost, bit1 no-ack, bit2 transfer done, bit3 receive ready, bit4 transmit ready, bit10 transmit underflow, bit11 receive overrun) are sticky. Writing 1 to a bit at 0x08 clears that bit, and writing 0 leaves it alone. An event in the same cycle as its clear leaves the flag set.
- R3: irq is high exactly when one of status bits 0 to 4 is set together with the same bit of the enable register at 0x04. Bits 10 and 11 never raise irq.
- R4: The vector register at 0x0C reads 1 plus the index of the lowest pending enabled source among bits 0 to 4, or 0 when no such source is pending.
- R5: In transmit mode, a write to the data register (0x1C) gives the engine bits 7:0 first and then bits 15:8. When only one byte of the count is left, only bits 7:0 are sent.
- R6: The transmit-ready flag (bit4) sets when a transmit transfer starts with a nonzero count. It also sets when the engine takes the last buffered byte while bytes of the count are still unwritten.
- R7: In receive mode, the receive-ready flag (bit3) sets once the buffer holds two bytes, or holds all bytes still owed to the host. A data read returns the first received byte in bits 7:0 and the second in bits 15:8, with bits 15:8 zero when only one byte was owed.
- R8: A byte pushed while the receive buffer already holds all it may hold is dropped and sets status bit11. An engine take while the transmit buffer is empty sets status bit10.
- R9: Writing 1 to bit1 of 0x20 returns all registers to their defaults. System status bit0 then reads 0 for RST_CYCLES cycles and reads 1 afterwards.
- R10: While control bit15 is 0, the status flags are held at 0, engine events are ignored and a start request gives no start pulse.
- R11: Status bit12 reads the engine's bus-busy input directly, and writes to it have no effect.
- R12: A control write with bit15 and bit0 set gives a one-cycle eng_start. The direction comes from bit9 (1 = transmit), and eng_stop_req follows bit1. Bit0 reads back as 0.
- R13: A data write in transmit mode while buffered bytes remain unsent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_re | input | 1 | Read strobe, one cycle (pops receive data) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_stop_req | output | 1 | Finish the transfer with a stop condition |
| eng_tx_dir | output | 1 | 1 = transmit, 0 = receive |
| eng_ten_bit | output | 1 | Use 10-bit target addressing |
| eng_addr | output | ADDR_W | Target address |
| eng_count | output | CNT_W | Byte count |
| eng_own_addr | output | ADDR_W | Own address |
| eng_psc | output | PSC_W | Clock prescaler |
| eng_scl_lo | output | SCL_W | SCL low phase length |
| eng_scl_hi | output | SCL_W | SCL high phase length |
| eng_tx_valid | output | 1 | A transmit byte is available |
| eng_tx_byte | output | 8 | Next transmit byte |
| eng_tx_take | input | 1 | Engine consumes the transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_ev_arb | input | 1 | Arbitration lost event |
| eng_ev_nack | input | 1 | No-acknowledge event |
| eng_ev_done | input | 1 | Transfer done event |
| eng_busy | input | 1 | Bus busy level |

## Verification
The bench targets byte order and partial words. A design that swaps the halves, or passes on a stale upper byte for an odd count, would send or return wrong bytes. It hits the write-one-to-clear edge where an event lands on its own clear cycle, which a design that lets the clear win would lose. It pushes a third receive byte into a full buffer and takes from an empty transmit buffer, checking that the byte is dropped and the error flag is raised without touching irq. It counts the exact number of cycles the reset-done flag stays low after a soft reset, and checks that a disabled module drops events and start requests.

// File: rtl/i2cfe_pkg.sv
`timescale 1ns/1ps
package i2cfe_pkg;
  // register byte offsets seen by software
  localparam logic [5:0] OFF_REV  = 6'h00;
  localparam logic [5:0] OFF_IE   = 6'h04;
  localparam logic [5:0] OFF_STAT = 6'h08;
  localparam logic [5:0] OFF_IVEC = 6'h0C;
  localparam logic [5:0] OFF_SYSS = 6'h10;
  localparam logic [5:0] OFF_CNT  = 6'h18;
  localparam logic [5:0] OFF_DATA = 6'h1C;
  localparam logic [5:0] OFF_SYSC = 6'h20;
  localparam logic [5:0] OFF_CTRL = 6'h24;
  localparam logic [5:0] OFF_OWN  = 6'h28;
  localparam logic [5:0] OFF_SLV  = 6'h2C;
  localparam logic [5:0] OFF_PSC  = 6'h30;
  localparam logic [5:0] OFF_SCLL = 6'h34;
  localparam logic [5:0] OFF_SCLH = 6'h38;

  // status bit positions
  localparam int ST_ARB  = 0;
  localparam int ST_NACK = 1;
  localparam int ST_DONE = 2;
  localparam int ST_RXR  = 3;
  localparam int ST_TXR  = 4;
  localparam int ST_UDF  = 10;
  localparam int ST_OVR  = 11;
  localparam int ST_BUSY = 12;
  localparam int NSRC    = 5;
  localparam logic [15:0] ST_KEEP = 16'h0C1F;

  // control bit positions
  localparam int CT_EN  = 15;
  localparam int CT_MST = 10;
  localparam int CT_TRX = 9;
  localparam int CT_TEN = 8;
  localparam int CT_STP = 1;
  localparam int CT_STT = 0;

  // 1 + index of the lowest set bit, 0 when none
  function automatic logic [2:0] lowest_src(input logic [NSRC-1:0] pend);
    logic [2:0] v;
    v = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) v = 3'(i + 1);
    end
    return v;
  endfunction

  // bytes that belong in one 16-bit word given bytes left
  function automatic logic [1:0] chunk(input logic [31:0] left);
    return (left >= 32'd2) ? 2'd2 : left[1:0];
  endfunction
endpackage

// File: rtl/i2cfe_txpack.sv
`timescale 1ns/1ps
module i2cfe_txpack #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             wr,
  input  logic [15:0]      wdata,
  input  logic             take,
  output logic             valid,
  output logic [7:0]       byte_o,
  output logic             want,
  output logic             udf
);
  import i2cfe_pkg::*;

  logic [CNT_W-1:0] left_q;
  logic [1:0]       fill_q;
  logic [15:0]      hold_q;
  logic [1:0]       n_take;
  logic             accept;

  assign n_take = chunk(32'(left_q));
  assign accept = wr && (fill_q == 2'd0) && (left_q != '0) && !clr && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      fill_q <= '0;
      hold_q <= '0;
    end else if (clr) begin
      left_q <= '0;
      fill_q <= '0;
      hold_q <= '0;
    end else if (load) begin
      left_q <= load_cnt;
      fill_q <= '0;
      hold_q <= '0;
    end else if (accept) begin
      hold_q <= wdata;
      fill_q <= n_take;
      left_q <= left_q - CNT_W'(n_take);
    end else if (take && fill_q != 2'd0) begin
      hold_q <= {8'h00, hold_q[15:8]};
      fill_q <= fill_q - 2'd1;
    end
  end

  assign valid  = (fill_q != 2'd0);
  assign byte_o = hold_q[7:0];
  assign want   = !clr && (load ? (load_cnt != '0)
                                : (take && fill_q == 2'd1 && left_q != '0));
  assign udf    = !clr && !load && take && (fill_q == 2'd0);
endmodule

// File: rtl/i2cfe_rxpack.sv
`timescale 1ns/1ps
module i2cfe_rxpack #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             pop,
  input  logic             push,
  input  logic [7:0]       push_byte,
  output logic [15:0]      word,
  output logic             ready_set,
  output logic             ovr
);
  import i2cfe_pkg::*;

  logic [CNT_W-1:0] left_q, left_a;
  logic [1:0]       fill_q, fill_a, need_a;
  logic [15:0]      hold_q, hold_a, hold_n;
  logic             full_push, accept;

  always_comb begin
    left_a    = pop ? (left_q - CNT_W'(fill_q)) : left_q;
    fill_a    = pop ? 2'd0 : fill_q;
    hold_a    = pop ? 16'h0000 : hold_q;
    need_a    = chunk(32'(left_a));
    full_push = push && (fill_a == need_a);
    accept    = push && !full_push;
    hold_n    = hold_a;
    if (accept) begin
      if (fill_a[0]) hold_n[15:8] = push_byte;
      else           hold_n[7:0]  = push_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      fill_q <= '0;
      hold_q <= '0;
    end else if (clr) begin
      left_q <= '0;
      fill_q <= '0;
      hold_q <= '0;
    end else if (load) begin
      left_q <= load_cnt;
      fill_q <= '0;
      hold_q <= '0;
    end else begin
      left_q <= left_a;
      fill_q <= fill_a + {1'b0, accept};
      hold_q <= hold_n;
    end
  end

  assign word      = hold_q;
  assign ready_set = !clr && !load && accept && ((fill_a + 2'd1) == need_a);
  assign ovr       = !clr && !load && full_push;
endmodule

// File: rtl/i2cfe_status.sv
`timescale 1ns/1ps
module i2cfe_status (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [15:0]                 set,
  input  logic [15:0]                 w1c,
  input  logic [i2cfe_pkg::NSRC-1:0]  ie,
  output logic [15:0]                 stat,
  output logic                        irq,
  output logic [2:0]                  vec
);
  import i2cfe_pkg::*;

  logic [NSRC-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= '0;
    else          stat <= ((stat & ~w1c) | set) & ST_KEEP;
  end

  assign pend = stat[NSRC-1:0] & ie;
  assign irq  = |pend;
  assign vec  = lowest_src(pend);
endmodule

// File: rtl/i2c_host_regs.sv
`timescale 1ns/1ps
module i2c_host_regs #(
  parameter int          CNT_W      = 16,
  parameter int          ADDR_W     = 10,
  parameter int          PSC_W      = 8,
  parameter int          SCL_W      = 8,
  parameter int          RST_CYCLES = 4,
  parameter logic [15:0] REV_ID     = 16'h0021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_stop_req,
  output logic              eng_tx_dir,
  output logic              eng_ten_bit,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [CNT_W-1:0]  eng_count,
  output logic [ADDR_W-1:0] eng_own_addr,
  output logic [PSC_W-1:0]  eng_psc,
  output logic [SCL_W-1:0]  eng_scl_lo,
  output logic [SCL_W-1:0]  eng_scl_hi,
  output logic              eng_tx_valid,
  output logic [7:0]        eng_tx_byte,
  input  logic              eng_tx_take,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_ev_arb,
  input  logic              eng_ev_nack,
  input  logic              eng_ev_done,
  input  logic              eng_busy
);
  import i2cfe_pkg::*;

  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0]   rc_q;
  logic              en_q, mst_q, trx_q, ten_q, stp_q, start_q, mode_tx_q;
  logic [NSRC-1:0]   ie_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] own_q, slv_q;
  logic [PSC_W-1:0]  psc_q;
  logic [SCL_W-1:0]  scll_q, sclh_q;

  // named internal events
  logic        resetting, srst_fire, hold, act_clr, ctrl_wr, start_fire;
  logic        tx_load, rx_load, data_wr, data_rd, stat_wr;
  logic        tx_want, tx_udf, rx_ready, rx_ovr;
  logic [15:0] rx_word, ev_set, w1c, stat_q;
  logic [2:0]  ivec;

  assign resetting  = (rc_q != '0);
  assign srst_fire  = bus_we && (bus_addr == OFF_SYSC) && bus_wdata[1];
  assign hold       = !en_q || resetting || srst_fire;
  assign ctrl_wr    = bus_we && (bus_addr == OFF_CTRL) && !resetting && !srst_fire;
  assign start_fire = ctrl_wr && bus_wdata[CT_EN] && bus_wdata[CT_STT];
  assign act_clr    = hold && !start_fire;
  assign tx_load    = start_fire && bus_wdata[CT_TRX];
  assign rx_load    = start_fire && !bus_wdata[CT_TRX];
  assign data_wr    = bus_we && (bus_addr == OFF_DATA) && !hold && mode_tx_q;
  assign data_rd    = bus_re && (bus_addr == OFF_DATA) && !hold && !mode_tx_q;
  assign stat_wr    = bus_we && (bus_addr == OFF_STAT) && !hold;
  assign w1c        = stat_wr ? bus_wdata : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rc_q <= '0;
    else if (srst_fire) rc_q <= RC_W'(RST_CYCLES);
    else if (resetting) rc_q <= rc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; trx_q <= 1'b0; ten_q <= 1'b0; stp_q <= 1'b0;
      start_q <= 1'b0; mode_tx_q <= 1'b0; ie_q <= '0; cnt_q <= '0;
      own_q <= '0; slv_q <= '0; psc_q <= '0; scll_q <= '0; sclh_q <= '0;
    end else if (resetting || srst_fire) begin
      en_q <= 1'b0; mst_q <= 1'b0; trx_q <= 1'b0; ten_q <= 1'b0; stp_q <= 1'b0;
      start_q <= 1'b0; mode_tx_q <= 1'b0; ie_q <= '0; cnt_q <= '0;
      own_q <= '0; slv_q <= '0; psc_q <= '0; scll_q <= '0; sclh_q <= '0;
    end else begin
      start_q <= start_fire;
      if (start_fire) mode_tx_q <= bus_wdata[CT_TRX];
      if (ctrl_wr) begin
        en_q  <= bus_wdata[CT_EN];
        mst_q <= bus_wdata[CT_MST];
        trx_q <= bus_wdata[CT_TRX];
        ten_q <= bus_wdata[CT_TEN];
        stp_q <= bus_wdata[CT_STP];
      end
      if (bus_we) begin
        case (bus_addr)
          OFF_IE:   ie_q   <= bus_wdata[NSRC-1:0];
          OFF_CNT:  cnt_q  <= CNT_W'(bus_wdata);
          OFF_OWN:  own_q  <= ADDR_W'(bus_wdata);
          OFF_SLV:  slv_q  <= ADDR_W'(bus_wdata);
          OFF_PSC:  psc_q  <= PSC_W'(bus_wdata);
          OFF_SCLL: scll_q <= SCL_W'(bus_wdata);
          OFF_SCLH: sclh_q <= SCL_W'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  i2cfe_txpack #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(act_clr), .load(tx_load), .load_cnt(cnt_q),
    .wr(data_wr), .wdata(bus_wdata), .take(eng_tx_take),
    .valid(eng_tx_valid), .byte_o(eng_tx_byte), .want(tx_want), .udf(tx_udf)
  );

  i2cfe_rxpack #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(act_clr), .load(rx_load), .load_cnt(cnt_q),
    .pop(data_rd), .push(eng_rx_push), .push_byte(eng_rx_byte),
    .word(rx_word), .ready_set(rx_ready), .ovr(rx_ovr)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[ST_ARB]  = eng_ev_arb;
    ev_set[ST_NACK] = eng_ev_nack;
    ev_set[ST_DONE] = eng_ev_done;
    ev_set[ST_RXR]  = rx_ready;
    ev_set[ST_TXR]  = tx_want;
    ev_set[ST_UDF]  = tx_udf;
    ev_set[ST_OVR]  = rx_ovr;
  end

  i2cfe_status u_st (
    .clk(clk), .rst_n(rst_n), .clr(act_clr), .set(ev_set), .w1c(w1c),
    .ie(ie_q), .stat(stat_q), .irq(irq), .vec(ivec)
  );

  always_comb begin
    bus_rdata = 16'h0000;
    case (bus_addr)
      OFF_REV:  bus_rdata = REV_ID;
      OFF_IE:   bus_rdata = 16'(ie_q);
      OFF_STAT: bus_rdata = stat_q | (16'(eng_busy) << ST_BUSY);
      OFF_IVEC: bus_rdata = 16'(ivec);
      OFF_SYSS: bus_rdata = {15'h0000, !resetting};
      OFF_CNT:  bus_rdata = 16'(cnt_q);
      OFF_DATA: bus_rdata = rx_word;
      OFF_SYSC: bus_rdata = {14'h0000, resetting, 1'b0};
      OFF_CTRL: bus_rdata = {en_q, 4'h0, mst_q, trx_q, ten_q, 6'h00, stp_q, 1'b0};
      OFF_OWN:  bus_rdata = 16'(own_q);
      OFF_SLV:  bus_rdata = 16'(slv_q);
      OFF_PSC:  bus_rdata = 16'(psc_q);
      OFF_SCLL: bus_rdata = 16'(scll_q);
      OFF_SCLH: bus_rdata = 16'(sclh_q);
      default:  bus_rdata = 16'h0000;
    endcase
  end

  assign eng_start    = start_q;
  assign eng_stop_req = stp_q;
  assign eng_tx_dir   = trx_q;
  assign eng_ten_bit  = ten_q;
  assign eng_addr     = slv_q;
  assign eng_count    = cnt_q;
  assign eng_own_addr = own_q;
  assign eng_psc      = psc_q;
  assign eng_scl_lo   = scll_q;
  assign eng_scl_hi   = sclh_q;
endmodule

// File: rtl/i2c_host_regs_chk.sv
`timescale 1ns/1ps
module i2c_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [2:0]  ivec,
  input logic        eng_start,
  input logic        eng_tx_valid,
  input logic        eng_tx_take,
  input logic [7:0]  eng_tx_byte,
  input logic        hold,
  input logic        start_fire,
  input logic        rx_ovr,
  input logic [15:0] stat_q,
  input logic        stat_wr,
  input logic        resetting,
  input logic        en_q
);
  // irq and the vector come from separate paths and must agree
  assert_irq_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ivec != 3'd0));

  assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_tx_byte_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_take && !hold && !start_fire)
      |=> (eng_tx_valid && $stable(eng_tx_byte)));

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !hold) |=> stat_q[11]);

  assert_clear_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_q) & ~stat_q)) |-> ($past(stat_wr) || $past(hold)));

  assert_soft_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> (!en_q && stat_q == 16'h0000));
endmodule

bind i2c_host_regs i2c_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ivec(ivec), .eng_start(eng_start),
  .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte),
  .hold(hold), .start_fire(start_fire), .rx_ovr(rx_ovr), .stat_q(stat_q),
  .stat_wr(stat_wr), .resetting(resetting), .en_q(en_q)
);

// File: tb/i2c_host_regs_bench.sv
`timescale 1ns/1ps
module i2c_host_regs_bench;
  localparam int          RSTC = 4;
  localparam logic [15:0] REV  = 16'h0021;
  localparam logic [5:0] A_REV = 6'h00, A_IE = 6'h04, A_STAT = 6'h08, A_IVEC = 6'h0C,
                         A_SYSS = 6'h10, A_CNT = 6'h18, A_DATA = 6'h1C, A_SYSC = 6'h20,
                         A_CTRL = 6'h24, A_SLV = 6'h2C, A_PSC = 6'h30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq, eng_start, eng_stop_req, eng_tx_dir, eng_ten_bit;
  logic [9:0]  eng_addr, eng_own_addr;
  logic [15:0] eng_count;
  logic [7:0]  eng_psc, eng_scl_lo, eng_scl_hi, eng_tx_byte;
  logic        eng_tx_valid;
  logic        eng_tx_take = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_ev_arb = 1'b0, eng_ev_nack = 1'b0, eng_ev_done = 1'b0, eng_busy = 1'b0;

  int total = 0;
  int bad = 0;

  i2c_host_regs #(.RST_CYCLES(RSTC), .REV_ID(REV)) u_i2c_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_start(eng_start), .eng_stop_req(eng_stop_req), .eng_tx_dir(eng_tx_dir),
    .eng_ten_bit(eng_ten_bit), .eng_addr(eng_addr), .eng_count(eng_count),
    .eng_own_addr(eng_own_addr), .eng_psc(eng_psc), .eng_scl_lo(eng_scl_lo),
    .eng_scl_hi(eng_scl_hi), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
    .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .eng_ev_arb(eng_ev_arb), .eng_ev_nack(eng_ev_nack), .eng_ev_done(eng_ev_done),
    .eng_busy(eng_busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, 32'(v), 32'(exp));
  endtask

  task automatic take_byte();
    eng_tx_take = 1'b1; @(negedge clk); eng_tx_take = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_byte = b; @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic test_reset_state();
    rdchk("R1 control", A_CTRL, 16'h0000);
    rdchk("R1 status", A_STAT, 16'h0000);
    rdchk("R1 enable", A_IE, 16'h0000);
    rdchk("R1 prescaler", A_PSC, 16'h0000);
    rdchk("R1 sys status", A_SYSS, 16'h0001);
    rdchk("R1 revision", A_REV, REV);
    check("R1 irq", 32'(irq), 32'd0);
  endtask

  task automatic test_transmit();
    wr(A_IE, 16'h001F);
    wr(A_CNT, 16'd3);
    wr(A_SLV, 16'h0050);
    wr(A_CTRL, 16'h8603);
    check("R12 start pulse", 32'(eng_start), 32'd1);
    check("R12 direction", 32'(eng_tx_dir), 32'd1);
    check("R12 stop level", 32'(eng_stop_req), 32'd1);
    check("R12 address", 32'(eng_addr), 32'h50);
    check("R12 count", 32'(eng_count), 32'd3);
    rdchk("R12 start bit reads 0", A_CTRL, 16'h8602);
    check("R12 pulse one cycle", 32'(eng_start), 32'd0);
    rdchk("R6 tx ready on start", A_STAT, 16'h0010);
    check("R3 irq on tx ready", 32'(irq), 32'd1);
    rdchk("R4 vector tx ready", A_IVEC, 16'd5);
    wr(A_DATA, 16'hBBAA);
    check("R5 first byte low", 32'(eng_tx_byte), 32'hAA);
    check("R5 valid", 32'(eng_tx_valid), 32'd1);
    wr(A_DATA, 16'h1234);
    check("R13 write ignored", 32'(eng_tx_byte), 32'hAA);
    wr(A_STAT, 16'h0010);
    rdchk("R2 tx ready cleared", A_STAT, 16'h0000);
    take_byte();
    check("R5 second byte high", 32'(eng_tx_byte), 32'hBB);
    take_byte();
    check("R5 drained", 32'(eng_tx_valid), 32'd0);
    rdchk("R6 tx ready on drain", A_STAT, 16'h0010);
    wr(A_STAT, 16'h0010);
    wr(A_DATA, 16'h77CC);
    check("R5 odd tail low byte", 32'(eng_tx_byte), 32'hCC);
    take_byte();
    check("R5 only one byte sent", 32'(eng_tx_valid), 32'd0);
    rdchk("R6 no tx ready when done", A_STAT, 16'h0000);
    take_byte();
    rdchk("R8 underflow flag", A_STAT, 16'h0400);
    check("R3 underflow no irq", 32'(irq), 32'd0);
    wr(A_STAT, 16'h0400);
  endtask

  task automatic test_w1c();
    eng_ev_done = 1'b1; @(negedge clk); eng_ev_done = 1'b0;
    rdchk("R2 done set", A_STAT, 16'h0004);
    wr(A_STAT, 16'h0000);
    rdchk("R2 zero write keeps", A_STAT, 16'h0004);
    wr(A_STAT, 16'hFFFB);
    rdchk("R2 other ones keep", A_STAT, 16'h0004);
    eng_ev_done = 1'b1;
    wr(A_STAT, 16'h0004);
    eng_ev_done = 1'b0;
    rdchk("R2 event beats clear", A_STAT, 16'h0004);
    wr(A_STAT, 16'h0004);
    rdchk("R2 cleared", A_STAT, 16'h0000);
  endtask

  task automatic test_vector();
    wr(A_IE, 16'h001E);
    eng_ev_arb = 1'b1; eng_ev_nack = 1'b1; @(negedge clk);
    eng_ev_arb = 1'b0; eng_ev_nack = 1'b0;
    rdchk("R2 both flags", A_STAT, 16'h0003);
    rdchk("R4 masked lowest skipped", A_IVEC, 16'd2);
    check("R3 irq masked mix", 32'(irq), 32'd1);
    wr(A_IE, 16'h0000);
    check("R3 irq all masked", 32'(irq), 32'd0);
    rdchk("R4 vector none", A_IVEC, 16'd0);
    wr(A_IE, 16'h001F);
    rdchk("R4 vector arb", A_IVEC, 16'd1);
    wr(A_STAT, 16'h0003);
  endtask

  task automatic test_receive();
    wr(A_CNT, 16'd3);
    wr(A_CTRL, 16'h8403);
    check("R12 receive direction", 32'(eng_tx_dir), 32'd0);
    push_byte(8'h11);
    rdchk("R7 no ready at one of two", A_STAT, 16'h0000);
    push_byte(8'h22);
    rdchk("R7 ready at two", A_STAT, 16'h0008);
    rdchk("R4 vector rx ready", A_IVEC, 16'd4);
    push_byte(8'h33);
    rdchk("R8 overrun flag", A_STAT, 16'h0808);
    rdchk("R7 word order", A_DATA, 16'h2211);
    wr(A_STAT, 16'h0808);
    push_byte(8'h44);
    rdchk("R7 ready for last byte", A_STAT, 16'h0008);
    rdchk("R7 last word upper zero", A_DATA, 16'h0044);
    wr(A_STAT, 16'h0008);
  endtask

  task automatic test_busy();
    eng_busy = 1'b1; #1;
    rdchk("R11 busy shown", A_STAT, 16'h1000);
    wr(A_STAT, 16'h1000);
    rdchk("R11 busy not cleared", A_STAT, 16'h1000);
    eng_busy = 1'b0; #1;
    rdchk("R11 busy follows", A_STAT, 16'h0000);
  endtask

  task automatic test_disable();
    eng_ev_nack = 1'b1; @(negedge clk); eng_ev_nack = 1'b0;
    wr(A_CTRL, 16'h0000);
    @(negedge clk);
    rdchk("R10 status held zero", A_STAT, 16'h0000);
    eng_ev_arb = 1'b1; @(negedge clk); eng_ev_arb = 1'b0;
    rdchk("R10 event ignored", A_STAT, 16'h0000);
    check("R10 irq low", 32'(irq), 32'd0);
    wr(A_CTRL, 16'h0201);
    check("R10 no start when disabled", 32'(eng_start), 32'd0);
    rdchk("R10 still disabled", A_CTRL, 16'h0200);
  endtask

  task automatic test_soft_reset();
    wr(A_CTRL, 16'h8000);
    wr(A_PSC, 16'h0005);
    check("R9 prescaler out before", 32'(eng_psc), 32'h05);
    wr(A_SYSC, 16'h0002);
    for (int i = 0; i < RSTC; i++) rdchk("R9 done low", A_SYSS, 16'h0000);
    rdchk("R9 done high", A_SYSS, 16'h0001);
    rdchk("R9 control default", A_CTRL, 16'h0000);
    rdchk("R9 enable default", A_IE, 16'h0000);
    rdchk("R9 prescaler default", A_PSC, 16'h0000);
    check("R9 prescaler out", 32'(eng_psc), 32'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_state();
    wr(A_CTRL, 16'h8000);
    test_transmit();
    test_w1c();
    test_vector();
    test_receive();
    test_busy();
    test_disable();
    test_soft_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule